// File: doc/BRIEF.md
# Grouped Interrupt Event Controller

This block sits between a network MAC datapath and a chip interrupt controller. Each datapath event arrives as a one-cycle pulse and sets its own bit in a sticky event register. Software reads that register to poll what has happened and clears bits by writing ones. A companion mask register decides which recorded events may raise an interrupt. An event is recorded even when its mask bit is off.

The enabled events drive three separate interrupt lines. One line is for transmit frame and buffer activity and one is for receive activity. The third collects twenty-one error, diagnostic and special events. The transmit and receive lines each pass through a coalescing unit that can hold the line back. The unit releases the line once a set number of frame events has arrived, or once a tick timeout runs out while a frame is pending. A unit built with a frame threshold of zero is bypassed, and its line then follows the enabled bits directly.

Top module: `irq_event_ctrl`

## Requirements
- R1: A pulse on `event_pulse_i[n]` sets event bit n at the next clock edge, whatever the mask holds. The event register reads on `bus_rdata_o` when `bus_addr_i` is 0. Bit 0 is transmit-buffer, bit 1 is transmit-frame, bit 2 is receive-buffer, bit 3 is receive-frame, and bits 4 to 24 are the error/diagnostic/special group.
- R2: A write to address 0 clears every event bit whose data bit is 1 and leaves the bits written with 0 unchanged. Bits 25 to 31 are never set and always read 0.
- R3: When an event pulse and a write-one-clear hit the same bit in the same cycle, the bit stays set.
- R4: The mask register sits at address 1. A write replaces it, bits 25 to 31 always read 0, and it resets to zero.
- R5: `irq_err_o` is high exactly while some bit in positions 4 to 24 is set in both the event and mask registers. It stays high until every such enabled bit is cleared.
- R6: With transmit coalescing active (TX_FRAMES = 4 by default), `irq_tx_o` rises in the cycle after the fourth transmit-frame pulse, provided bit 0 or bit 1 is set and enabled.
- R7: With fewer frames than the threshold, `irq_tx_o` rises TX_TICKS (default 16) clock edges after the edge that captured the first pending frame pulse, and not one edge earlier.
- R8: Clearing the transmit-frame bit resets the frame count and the timer. After the clear, a full threshold of new pulses is needed before the line rises again.
- R9: Receive coalescing is bypassed by default (RX_FRAMES = 0). `irq_rx_o` rises the cycle after bit 2 or bit 3 is set and enabled, and falls only after both are cleared.
- R10: After reset both registers read zero and all three interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_pulse_i | input | 32 | One-cycle event pulses, one per event bit |
| bus_wr_i | input | 1 | Single-cycle register write strobe |
| bus_addr_i | input | 1 | 0 selects the event register, 1 selects the mask register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register |
| irq_tx_o | output | 1 | Transmit interrupt line |
| irq_rx_o | output | 1 | Receive interrupt line |
| irq_err_o | output | 1 | Error/diagnostic/special interrupt line |

## Verification
A corrupted event bit shows up on the very next read of address 0. Whenever that bit is enabled, it also shows up as a wrong level on its interrupt line in the same cycle. Faults in the coalescing state show only in time: a count or timer that is off or was not reset moves the rising edge of `irq_tx_o`. The bench therefore samples that line one edge before and exactly at the expected edge, both for the threshold case and for the timeout case. The same-cycle clear/pulse collision is checked by reading the bit back right after the colliding edge.

// File: rtl/irq_event_pkg.sv
// Package: shared bit positions and group masks for the interrupt event controller.
// Assumes a 32-bit register layout; positions 25..31 are unimplemented.
package irq_event_pkg;
    localparam int REG_W    = 32;
    localparam int TXB_BIT  = 0;
    localparam int TXF_BIT  = 1;
    localparam int RXB_BIT  = 2;
    localparam int RXF_BIT  = 3;
    localparam int ERR_LO   = 4;
    localparam int ERR_N    = 21;
    localparam int IMPL_N   = ERR_LO + ERR_N;

    localparam logic [REG_W-1:0] TX_GRP   = (32'h1 << TXB_BIT) | (32'h1 << TXF_BIT);
    localparam logic [REG_W-1:0] RX_GRP   = (32'h1 << RXB_BIT) | (32'h1 << RXF_BIT);
    localparam logic [REG_W-1:0] ERR_GRP  = ((32'h1 << ERR_N) - 32'h1) << ERR_LO;
    localparam logic [REG_W-1:0] IMPL_MSK = (32'h1 << IMPL_N) - 32'h1;
endpackage

// File: rtl/evt_store.sv
// Module: sticky event register.
// Each implemented bit is set by its pulse and cleared by a write-one-clear
// vector; a pulse in the same cycle as a clear wins. Unimplemented bits stay 0.
module evt_store
    import irq_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] pulse_i,
    input  logic [REG_W-1:0] clr_i,
    output logic [REG_W-1:0] evt_o
);
    logic [REG_W-1:0] evt_q;
    logic [REG_W-1:0] set_v;

    // Restrict incoming pulses to implemented positions.
    assign set_v = pulse_i & IMPL_MSK;

    // Update the sticky bits: clear first, then let new events override.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr_i) | set_v;
    end

    assign evt_o = evt_q;

    AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((evt_q & $past(set_v)) == $past(set_v)));   // R1 R3
    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(evt_q) & ~$past(clr_i)) & ~evt_q) == '0));   // R2
endmodule

// File: rtl/mask_reg.sv
// Module: interrupt enable register.
// A write replaces the contents; unimplemented positions are forced to 0.
module mask_reg
    import irq_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] msk_o
);
    logic [REG_W-1:0] msk_q;

    // Load the enable bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    msk_q <= '0;
        else if (wr_i) msk_q <= wdata_i & IMPL_MSK;
    end

    assign msk_o = msk_q;

    AST_MASK_IMPL: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((msk_q & ~IMPL_MSK) == '0));   // R4
endmodule

// File: rtl/irq_coal.sv
// Module: frame-event coalescing gate.
// Counts frame pulses and the ticks since the first pending one, and raises
// fire_o once the count reaches FRAMES or TICKS ticks pass with a frame pending.
// A clear of the frame bit restarts both. FRAMES = 0 bypasses the unit (fire_o = 1).
// Assumes TICKS >= 1.
module irq_coal #(
    parameter int FRAMES = 4,
    parameter int TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse_i,
    input  logic frame_clr_i,
    output logic fire_o
);
    generate
        if (FRAMES == 0) begin : g_bypass
            logic unused_ok;
            assign unused_ok = ^{clk, rst_n, frame_pulse_i, frame_clr_i};
            assign fire_o    = 1'b1;
        end else begin : g_coal
            localparam int CW = $clog2(FRAMES + 1);
            localparam int TW = $clog2(TICKS + 1);
            localparam logic [CW-1:0] CNT_MAX = CW'(FRAMES);
            localparam logic [TW-1:0] TMR_END = TW'(TICKS - 1);

            logic [CW-1:0] cnt_q, cnt_d;
            logic [TW-1:0] tmr_q, tmr_d;
            logic          met_q, met_d, expire;

            // Timeout reached with a frame pending and no clear in flight.
            assign expire = !frame_clr_i && (cnt_q != '0) && (tmr_q == TMR_END);

            // Next frame count, saturating at the threshold.
            always_comb begin
                if (frame_clr_i)                            cnt_d = CW'(frame_pulse_i);
                else if (frame_pulse_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
                else                                        cnt_d = cnt_q;
            end

            // Next timer value, running only while frames are pending.
            always_comb begin
                if (frame_clr_i || cnt_q == '0) tmr_d = '0;
                else if (tmr_q != TMR_END)      tmr_d = tmr_q + 1'b1;
                else                            tmr_d = tmr_q;
            end

            // Sticky release flag, dropped by a clear.
            assign met_d = (frame_clr_i ? 1'b0 : met_q) | (cnt_d == CNT_MAX) | expire;

            // Register count, timer and release flag.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    tmr_q <= '0;
                    met_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_d;
                    tmr_q <= tmr_d;
                    met_q <= met_d;
                end
            end

            assign fire_o = met_q;

            AST_COAL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
                ((cnt_q != '0) && (tmr_q == TMR_END) && !frame_clr_i) |=> met_q);   // R7
            AST_COAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                (frame_clr_i && !frame_pulse_i) |=> (!met_q && cnt_q == '0));      // R8
        end
    endgenerate
endmodule

// File: rtl/irq_event_ctrl.sv
// Module: grouped interrupt event controller (top).
// Holds the sticky event and mask registers behind a two-address register bus
// and drives three interrupt lines. The transmit and receive lines are gated by
// coalescing units. Assumes event pulses are one cycle wide and synchronous to clk.
module irq_event_ctrl
    import irq_event_pkg::*;
#(
    parameter int TX_FRAMES = 4,
    parameter int TX_TICKS  = 16,
    parameter int RX_FRAMES = 0,
    parameter int RX_TICKS  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] event_pulse_i,
    input  logic        bus_wr_i,
    input  logic        bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_tx_o,
    output logic        irq_rx_o,
    output logic        irq_err_o
);
    logic [REG_W-1:0] evt_q, msk_q, clr_v, act_v;
    logic             evt_wr, msk_wr, tx_fire, rx_fire;

    // Decode the register bus.
    assign evt_wr = bus_wr_i && !bus_addr_i;
    assign msk_wr = bus_wr_i &&  bus_addr_i;
    assign clr_v  = evt_wr ? bus_wdata_i : '0;

    evt_store u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (event_pulse_i),
        .clr_i   (clr_v),
        .evt_o   (evt_q)
    );

    mask_reg u_msk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (msk_wr),
        .wdata_i (bus_wdata_i),
        .msk_o   (msk_q)
    );

    irq_coal #(.FRAMES(TX_FRAMES), .TICKS(TX_TICKS)) u_tx_coal (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (event_pulse_i[TXF_BIT]),
        .frame_clr_i   (clr_v[TXF_BIT]),
        .fire_o        (tx_fire)
    );

    irq_coal #(.FRAMES(RX_FRAMES), .TICKS(RX_TICKS)) u_rx_coal (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (event_pulse_i[RXF_BIT]),
        .frame_clr_i   (clr_v[RXF_BIT]),
        .fire_o        (rx_fire)
    );

    // Enabled pending events.
    assign act_v = evt_q & msk_q;

    // Read mux.
    assign bus_rdata_o = bus_addr_i ? msk_q : evt_q;

    // Interrupt lines per group.
    assign irq_tx_o  = ((act_v & TX_GRP)  != '0) && tx_fire;
    assign irq_rx_o  = ((act_v & RX_GRP)  != '0) && rx_fire;
    assign irq_err_o =  (act_v & ERR_GRP) != '0;

    AST_TX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_o |-> ((evt_q & msk_q & TX_GRP) != '0));    // R6
    AST_RX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_o |-> ((evt_q & msk_q & RX_GRP) != '0));    // R9
    AST_ERR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err_o) |-> ((evt_q & msk_q & ERR_GRP) == '0));   // R5
endmodule

// File: tb/irq_event_ctrl_tb.sv
// Bench: scoreboard style. Driver tasks push expected items into a queue;
// a monitor pops and compares them against the ports.
module irq_event_ctrl_tb_top;
    localparam int TICKS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] event_pulse_i = '0;
    logic        bus_wr_i = 1'b0;
    logic        bus_addr_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_tx_o, irq_rx_o, irq_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string       req;
        bit          is_irq;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];
    event  chk_ev;

    always #4 clk = ~clk;

    irq_event_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_pulse_i (event_pulse_i),
        .bus_wr_i      (bus_wr_i),
        .bus_addr_i    (bus_addr_i),
        .bus_wdata_i   (bus_wdata_i),
        .bus_rdata_o   (bus_rdata_o),
        .irq_tx_o      (irq_tx_o),
        .irq_rx_o      (irq_rx_o),
        .irq_err_o     (irq_err_o)
    );

    // Monitor: pop expected items and compare with the ports.
    always @(chk_ev) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {29'd0, irq_err_o, irq_rx_o, irq_tx_o} : bus_rdata_o;
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input logic [31:0] ev, input bit wr, input bit addr,
                         input logic [31:0] wd);
        @(negedge clk);
        event_pulse_i = ev; bus_wr_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
        @(negedge clk);
        event_pulse_i = '0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic pulse(input logic [31:0] ev);
        drive(ev, 1'b0, 1'b0, '0);
    endtask

    task automatic wr_reg(input bit addr, input logic [31:0] d);
        drive('0, 1'b1, addr, d);
    endtask

    task automatic exp_irq(input string req, input logic [2:0] e);
        item_t it;
        it.req = req; it.is_irq = 1'b1; it.exp = {29'd0, e};
        sb_q.push_back(it);
        #1 -> chk_ev;
        #1;
    endtask

    task automatic exp_rd(input string req, input bit addr, input logic [31:0] e);
        item_t it;
        bus_addr_i = addr;
        it.req = req; it.is_irq = 1'b0; it.exp = e;
        #1 sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        exp_rd("R10 evt", 1'b0, 32'h0);
        exp_rd("R10 msk", 1'b1, 32'h0);
        exp_irq("R10 irq", 3'b000);

        // R1 record while masked
        pulse(32'h20);
        exp_rd("R1 masked event recorded", 1'b0, 32'h20);
        exp_irq("R5 masked bit gives no irq", 3'b000);

        // R5 error group OR and hold
        wr_reg(1'b1, 32'h420);
        exp_irq("R5 enabled error raises", 3'b100);
        pulse(32'h400);
        wr_reg(1'b0, 32'h20);
        exp_irq("R5 held by remaining bit", 3'b100);
        wr_reg(1'b0, 32'h400);
        exp_irq("R5 all cleared drops", 3'b000);

        // R2 write zero no effect, unused bits
        pulse(32'h8000_0040);
        wr_reg(1'b0, 32'h0);
        exp_rd("R2 zero write and unused bit", 1'b0, 32'h40);

        // R3 collision: pulse wins
        drive(32'h40, 1'b1, 1'b0, 32'h40);
        exp_rd("R3 event wins over clear", 1'b0, 32'h40);
        wr_reg(1'b0, 32'h40);
        exp_rd("R2 write-one clears", 1'b0, 32'h0);

        // R4 mask range
        wr_reg(1'b1, 32'hFFFF_FFFF);
        exp_rd("R4 mask implemented bits", 1'b1, 32'h01FF_FFFF);

        // R9 receive, coalescing bypassed
        wr_reg(1'b1, 32'h0C);
        pulse(32'h04);
        exp_irq("R9 rx buffer raises", 3'b010);
        pulse(32'h08);
        wr_reg(1'b0, 32'h04);
        exp_irq("R9 held by rx frame", 3'b010);
        wr_reg(1'b0, 32'h08);
        exp_irq("R9 both cleared drops", 3'b000);

        // R6 transmit threshold
        wr_reg(1'b1, 32'h03);
        pulse(32'h02); pulse(32'h02); pulse(32'h02);
        exp_irq("R6 below threshold", 3'b000);
        pulse(32'h02);
        exp_irq("R6 threshold reached", 3'b001);
        wr_reg(1'b0, 32'h03);
        exp_irq("R6 cleared drops", 3'b000);

        // R8 restart after clear
        pulse(32'h02); pulse(32'h02); pulse(32'h02);
        exp_irq("R8 count restarted", 3'b000);
        wr_reg(1'b0, 32'h03);

        // R7 timeout
        pulse(32'h02);
        tick(TICKS - 1);
        exp_irq("R7 one edge before timeout", 3'b000);
        tick(1);
        exp_irq("R7 timeout fires", 3'b001);
        wr_reg(1'b0, 32'h03);
        exp_irq("R8 clear after timeout", 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule